// File: doc/BRIEF.md
# Cartridge Bus Mailbox with Save Buffer

This block joins a console's cartridge bus to a slower local controller. The host reaches it through a dedicated I/O region, which is marked by an active-low region strobe. During each strobe, the low eight address bits select an operation. The block behaves like fixed logic and never holds the host up. Read data comes from a holding register that was loaded before the cycle began. The shared data lines are driven only while a read strobe is low, so a local ROM can use the same lines at every other time.

Behind the bus port there are two structures:

- **Command queue.** Host writes to general command addresses go into a small queue. The local controller pops entries from it.
- **Save buffer.** This is a byte-wide buffer with an auto-incrementing pointer, controlled by a small set of host operations. The host can stream a saved game out of it, one byte per read. It can also stream a new save into it and then raise a commit request to the local controller. The local controller fills or drains the buffer through its own port, but only while no host save or load session is open.

The strobe, the direction, the address and the data are brought into the block clock through a two-flop synchronizer. Each operation takes effect on the synchronized rising edge of the strobe.

Top module: `cart_mailbox`

## Requirements
- R1: After reset, `cmd_valid`, `cmd_overflow` and `commit_req` are 0. With `bus_sel_n` high, `bus_oe` is 0.
- R2: `bus_oe` is 1 exactly while `bus_sel_n` is low and `bus_wr_n` is high. During such a cycle, `bus_dout` equals {8'h00, buffer byte at the pointer}.
- R3: A host write to an address above 8'h04 places {address, data} into the command queue once the strobe ends. `cmd_code`/`cmd_data` show the oldest entry while `cmd_valid` is 1, and `cmd_pop` removes that entry.
- R4: The command queue holds `CMD_DEPTH` (4) entries. A write that arrives while the queue is full is dropped and sets `cmd_overflow`. Only reset clears `cmd_overflow`.
- R5: A host write to 8'h00 (load start) or 8'h01 (save start) sets the buffer pointer to 0 and opens a session.
- R6: A host write to 8'h02 stores data bits [7:0] at the pointer and then advances the pointer. The pointer wraps from 255 to 0.
- R7: A host read at 8'h02 returns the byte at the pointer. The pointer advances once the strobe ends, so the next read returns the following byte.
- R8: A host write to 8'h03 (commit) raises `commit_req` and closes the session. `commit_req` stays high until `commit_ack` clears it.
- R9: A host write to 8'h04 closes the session without raising `commit_req`.
- R10: `lcl_rdata` always shows the buffer byte at `lcl_addr`. `lcl_we` writes `lcl_wdata` there only while no session is open; otherwise the write is ignored.
- R11: Host reads at any address other than 8'h02 neither move the pointer nor enter the queue. Writes to 8'h00–8'h04 never enter the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low I/O region strobe from the host |
| bus_wr_n | input | 1 | Host direction, low for write |
| bus_addr | input | 8 | Low address byte of the host access |
| bus_din | input | 16 | Data lines as seen by the block |
| bus_dout | output | 16 | Read data toward the data lines |
| bus_oe | output | 1 | Drive enable for the data lines |
| cmd_valid | output | 1 | Command queue holds an entry |
| cmd_code | output | 8 | Address byte of the oldest entry |
| cmd_data | output | 16 | Data word of the oldest entry |
| cmd_pop | input | 1 | Remove the oldest entry |
| cmd_overflow | output | 1 | Sticky: a command was lost to a full queue |
| commit_req | output | 1 | Buffer ready to be stored permanently |
| commit_ack | input | 1 | Clears `commit_req` |
| lcl_addr | input | 8 | Local buffer address |
| lcl_we | input | 1 | Local buffer write enable |
| lcl_wdata | input | 8 | Local buffer write data |
| lcl_rdata | output | 8 | Local buffer read data |

## Verification
Some rules are checked by assertions on every cycle:

- The start operations zero the pointer, and each next-byte operation advances it by exactly one modulo the buffer size.
- The holding register stays still while the synchronized strobe is low.
- The queue count stays within its depth, and the overflow flag never falls once set.
- `commit_req` holds until it is acknowledged.

Other behaviour can only be shown by the bench scenarios:

- Bytes pass through the buffer in the right order, including across the 255-to-0 wrap.
- The entry lost on overflow is the newest one.
- Local writes are refused during a session.
- Reads at other addresses leave the pointer alone.
- The drive enable rises and falls with the raw read strobe.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam logic [7:0] OP_LOAD   = 8'h00;
  localparam logic [7:0] OP_SAVE   = 8'h01;
  localparam logic [7:0] OP_NEXT   = 8'h02;
  localparam logic [7:0] OP_COMMIT = 8'h03;
  localparam logic [7:0] OP_CLOSE  = 8'h04;
  localparam logic [7:0] OP_LAST   = OP_CLOSE;

  typedef struct packed {
    logic [7:0]  code;
    logic [15:0] data;
  } cmd_t;
endpackage

// File: rtl/cmb_sync.sv
module cmb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmb_fifo.sv
module cmb_fifo
  import cmb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t din,
  input  logic pop,
  output logic valid,
  output cmd_t dout,
  output logic ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  cmd_t          slots [DEPTH];
  logic [AW-1:0] wp, wp_n, rp, rp_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          ovf_n, full, do_push, do_pop;

  always_comb begin
    full    = (cnt == CW'(DEPTH));
    do_push = push & ~full;
    do_pop  = pop & (cnt != '0);
    wp_n    = wp + AW'(do_push);
    rp_n    = rp + AW'(do_pop);
    cnt_n   = cnt + CW'(do_push) - CW'(do_pop);
    ovf_n   = ovf | (push & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
      ovf <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= din;
  end

  assign valid = (cnt != '0);
  assign dout  = slots[rp];

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R4
endmodule

// File: rtl/cmb_savebuf.sv
module cmb_savebuf #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          close_i,
  input  logic          wr_next,
  input  logic          rd_next,
  input  logic [7:0]    wbyte,
  input  logic          freeze,
  input  logic [AW-1:0] lcl_addr,
  input  logic          lcl_we,
  input  logic [7:0]    lcl_wdata,
  output logic [7:0]    lcl_rdata,
  output logic [7:0]    hold_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr, ptr_n;
  logic          session, session_n;
  logic [7:0]    hold_n;
  logic          lcl_ok;

  always_comb begin
    ptr_n = ptr;
    if (start_i)                ptr_n = '0;
    else if (wr_next | rd_next) ptr_n = ptr + AW'(1);
    session_n = session;
    if (start_i)      session_n = 1'b1;
    else if (close_i) session_n = 1'b0;
    hold_n = freeze ? hold_o : mem[ptr];
    lcl_ok = lcl_we & ~session & ~wr_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      session <= 1'b0;
      hold_o  <= 8'h00;
    end else begin
      ptr     <= ptr_n;
      session <= session_n;
      hold_o  <= hold_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_next)     mem[ptr]      <= wbyte;
    else if (lcl_ok) mem[lcl_addr] <= lcl_wdata;
  end

  assign lcl_rdata = mem[lcl_addr];

  AST_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ptr == '0)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && (wr_next || rd_next)) |=> (ptr == $past(ptr) + AW'(1))); // R6
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(hold_o)); // R2
endmodule

// File: rtl/cart_mailbox.sv
module cart_mailbox
  import cmb_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int BUF_DEPTH = 256,
  localparam int BAW = $clog2(BUF_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel_n,
  input  logic           bus_wr_n,
  input  logic [7:0]     bus_addr,
  input  logic [15:0]    bus_din,
  output logic [15:0]    bus_dout,
  output logic           bus_oe,
  output logic           cmd_valid,
  output logic [7:0]     cmd_code,
  output logic [15:0]    cmd_data,
  input  logic           cmd_pop,
  output logic           cmd_overflow,
  output logic           commit_req,
  input  logic           commit_ack,
  input  logic [BAW-1:0] lcl_addr,
  input  logic           lcl_we,
  input  logic [7:0]     lcl_wdata,
  output logic [7:0]     lcl_rdata
);
  localparam int SW = 2 + 8 + 16;

  logic          rst_ns;
  logic [SW-1:0] sync_q;
  logic          sel_s, wr_n_s, sel_prev;
  logic [7:0]    addr_s, lat_addr;
  logic [15:0]   data_s, lat_data;
  logic          lat_wr;
  logic          ev, is_wr, op_start, op_commit, op_close, op_wnext, op_rnext, op_push;
  logic          commit_n;
  logic [7:0]    hold;
  cmd_t          push_d, head;

  cmb_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns));

  cmb_sync #(.W(SW), .STAGES(2), .RST_VAL({2'b11, 24'h0})) u_in_sync (
    .clk(clk), .rst_n(rst_ns), .d({bus_sel_n, bus_wr_n, bus_addr, bus_din}), .q(sync_q));

  assign {sel_s, wr_n_s, addr_s, data_s} = sync_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sel_prev <= 1'b1;
      lat_wr   <= 1'b0;
      lat_addr <= 8'h00;
      lat_data <= 16'h0000;
      commit_req <= 1'b0;
    end else begin
      sel_prev <= sel_s;
      if (!sel_s) begin
        lat_wr   <= ~wr_n_s;
        lat_addr <= addr_s;
        lat_data <= data_s;
      end
      commit_req <= commit_n;
    end
  end

  always_comb begin
    ev        = sel_s & ~sel_prev;
    is_wr     = ev & lat_wr;
    op_start  = is_wr & ((lat_addr == OP_LOAD) | (lat_addr == OP_SAVE));
    op_commit = is_wr & (lat_addr == OP_COMMIT);
    op_close  = is_wr & (lat_addr == OP_CLOSE);
    op_wnext  = is_wr & (lat_addr == OP_NEXT);
    op_rnext  = ev & ~lat_wr & (lat_addr == OP_NEXT);
    op_push   = is_wr & (lat_addr > OP_LAST);
    push_d    = '{code: lat_addr, data: lat_data};
    if (op_commit)       commit_n = 1'b1;
    else if (commit_ack) commit_n = 1'b0;
    else                 commit_n = commit_req;
  end

  cmb_fifo #(.DEPTH(CMD_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_ns), .push(op_push), .din(push_d), .pop(cmd_pop),
    .valid(cmd_valid), .dout(head), .ovf(cmd_overflow));

  cmb_savebuf #(.DEPTH(BUF_DEPTH), .AW(BAW)) u_buf (
    .clk(clk), .rst_n(rst_ns), .start_i(op_start), .close_i(op_commit | op_close),
    .wr_next(op_wnext), .rd_next(op_rnext), .wbyte(lat_data[7:0]), .freeze(~sel_s),
    .lcl_addr(lcl_addr), .lcl_we(lcl_we), .lcl_wdata(lcl_wdata),
    .lcl_rdata(lcl_rdata), .hold_o(hold));

  assign cmd_code = head.code;
  assign cmd_data = head.data;
  assign bus_oe   = ~bus_sel_n & bus_wr_n;
  assign bus_dout = {8'h00, hold};

  AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (commit_req && !commit_ack) |=> commit_req); // R8
  AST_COMMIT_DROP: assert property (@(posedge clk) disable iff (!rst_ns)
    (commit_req && commit_ack && !op_commit) |=> !commit_req); // R8
endmodule

// File: tb/cart_mailbox_tb.sv
module cart_mailbox_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel_n, bus_wr_n;
  logic [7:0]  bus_addr;
  logic [15:0] bus_din, bus_dout;
  logic        bus_oe, cmd_valid, cmd_pop, cmd_overflow, commit_req, commit_ack;
  logic [7:0]  cmd_code, lcl_addr, lcl_wdata, lcl_rdata;
  logic [15:0] cmd_data;
  logic        lcl_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] ref_mem [256];
  int         ref_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .cmd_overflow(cmd_overflow), .commit_req(commit_req), .commit_ack(commit_ack),
    .lcl_addr(lcl_addr), .lcl_we(lcl_we), .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata));

  function automatic logic [15:0] exp_read();
    return {8'h00, ref_mem[ref_ptr]};
  endfunction

  function automatic logic [7:0] rand_cmd_addr();
    return 8'h05 + 8'($urandom_range(0, 250));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_wr_n = 1'b0; bus_sel_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_sel_n = 1'b1; bus_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    if (a == 8'h02) begin
      ref_mem[ref_ptr] = d[7:0];
      ref_ptr = (ref_ptr + 1) % 256;
    end else if (a <= 8'h01) ref_ptr = 0;
  endtask

  task automatic host_read(logic [7:0] a, string req);
    @(negedge clk);
    bus_addr = a; bus_wr_n = 1'b1; bus_sel_n = 1'b0;
    #1;
    check({req, " oe during read"}, 32'(bus_oe), 32'd1);
    check({req, " read data"}, 32'(bus_dout), 32'(exp_read()));
    repeat (4) @(negedge clk);
    bus_sel_n = 1'b1;
    #1;
    check("R2 oe released", 32'(bus_oe), 32'd0);
    repeat (6) @(negedge clk);
    if (a == 8'h02) ref_ptr = (ref_ptr + 1) % 256;
  endtask

  task automatic lcl_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    lcl_addr = a; lcl_wdata = d; lcl_we = 1'b1;
    @(negedge clk);
    lcl_we = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk); cmd_pop = 1'b1;
    @(negedge clk); cmd_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] pd [5];
    logic [7:0]  pa [5];
    logic [7:0]  last, b;
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_sel_n = 1'b1; bus_wr_n = 1'b1; bus_addr = 8'h00; bus_din = 16'h0;
    cmd_pop = 1'b0; commit_ack = 1'b0; lcl_addr = 8'h00; lcl_we = 1'b0; lcl_wdata = 8'h00;
    ref_ptr = 0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 cmd_valid", 32'(cmd_valid), 0);
    check("R1 cmd_overflow", 32'(cmd_overflow), 0);
    check("R1 commit_req", 32'(commit_req), 0);
    check("R1 bus_oe", 32'(bus_oe), 0);

    // R2 oe stays low during a write strobe
    @(negedge clk); bus_wr_n = 1'b0; bus_sel_n = 1'b0; bus_addr = 8'h40; bus_din = 16'h1234;
    #1 check("R2 no drive on write", 32'(bus_oe), 0);
    repeat (3) @(negedge clk); bus_sel_n = 1'b1; bus_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 entry present", 32'(cmd_valid), 1);
    check("R3 code", 32'(cmd_code), 32'h40);
    check("R3 data", 32'(cmd_data), 32'h1234);
    pop_one();
    check("R3 pop empties", 32'(cmd_valid), 0);

    // R3 random commands
    for (int k = 0; k < 3; k++) begin
      pa[k] = rand_cmd_addr(); pd[k] = 16'($urandom);
      host_write(pa[k], pd[k]);
    end
    for (int k = 0; k < 3; k++) begin
      check("R3 random code", 32'(cmd_code), 32'(pa[k]));
      check("R3 random data", 32'(cmd_data), 32'(pd[k]));
      pop_one();
    end
    check("R3 drained", 32'(cmd_valid), 0);

    // R4 overflow drops the fifth entry
    for (int k = 0; k < 5; k++) begin
      pa[k] = rand_cmd_addr(); pd[k] = 16'($urandom);
      host_write(pa[k], pd[k]);
      if (k == 3) check("R4 no overflow at depth", 32'(cmd_overflow), 0);
    end
    check("R4 overflow set", 32'(cmd_overflow), 1);
    for (int k = 0; k < 4; k++) begin
      check("R4 kept entry", 32'({cmd_code, cmd_data}), 32'({pa[k], pd[k]}));
      pop_one();
    end
    check("R4 fifth dropped", 32'(cmd_valid), 0);
    check("R4 overflow sticky", 32'(cmd_overflow), 1);

    // R10 local fill while idle
    for (int k = 0; k < 16; k++) begin
      b = 8'($urandom);
      lcl_write(8'(k), b);
      ref_mem[k] = b;
    end
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); lcl_addr = 8'(k); #1;
      check("R10 local readback", 32'(lcl_rdata), 32'(ref_mem[k]));
    end

    // R5 R7 load session streaming reads
    host_write(8'h00, 16'h0000);
    for (int k = 0; k < 5; k++) host_read(8'h02, "R7");
    host_read(8'h09, "R11");
    host_read(8'h01, "R11");
    host_read(8'h02, "R11 pointer unmoved");
    check("R11 reads not queued", 32'(cmd_valid), 0);

    // R10 local write ignored during session
    @(negedge clk); lcl_addr = 8'h03; #1; last = lcl_rdata;
    lcl_write(8'h03, ~last);
    @(negedge clk); lcl_addr = 8'h03; #1;
    check("R10 write ignored in session", 32'(lcl_rdata), 32'(last));

    // R9 close without commit
    host_write(8'h04, 16'h0000);
    check("R9 no commit", 32'(commit_req), 0);
    lcl_write(8'h03, 8'h5A); ref_mem[3] = 8'h5A;
    @(negedge clk); lcl_addr = 8'h03; #1;
    check("R9 local write after close", 32'(lcl_rdata), 32'h5A);

    // R6 save with wrap across 256 bytes
    host_write(8'h01, 16'h0000);
    for (int k = 0; k < 257; k++) host_write(8'h02, 16'($urandom));
    check("R11 control writes not queued", 32'(cmd_valid), 0);
    host_write(8'h03, 16'h0000);
    check("R8 commit raised", 32'(commit_req), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); lcl_addr = 8'(k); #1;
      check("R6 buffer content", 32'(lcl_rdata), 32'(ref_mem[k]));
    end
    @(negedge clk); lcl_addr = 8'hFF; #1;
    check("R6 last slot", 32'(lcl_rdata), 32'(ref_mem[255]));
    repeat (3) @(negedge clk);
    check("R8 commit held", 32'(commit_req), 1);
    @(negedge clk); commit_ack = 1'b1;
    @(negedge clk); commit_ack = 1'b0;
    check("R8 ack clears", 32'(commit_req), 0);

    // R5 restart mid sequence
    host_write(8'h01, 16'h0000);
    host_write(8'h02, 16'h0011);
    host_write(8'h02, 16'h0022);
    host_write(8'h01, 16'h0000);
    host_write(8'h02, 16'h00C3);
    host_write(8'h03, 16'h0000);
    @(negedge clk); lcl_addr = 8'h00; #1;
    check("R5 restart overwrites slot 0", 32'(lcl_rdata), 32'hC3);
    @(negedge clk); lcl_addr = 8'h01; #1;
    check("R5 slot 1 kept", 32'(lcl_rdata), 32'h22);
    @(negedge clk); commit_ack = 1'b1;
    @(negedge clk); commit_ack = 1'b0;

    // R7 load of saved bytes via host
    host_write(8'h00, 16'h0000);
    for (int k = 0; k < 3; k++) host_read(8'h02, "R7 reload");
    host_write(8'h04, 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule